// File: doc/BRIEF.md
# Masked SIMD Broadcast Controller

This block pairs one instruction sequencer with a row of identical processing elements. The sequencer pulls 16-bit instructions from a small program store and hands every data operation to all elements in the same step. Each element holds four registers, a private 256-word data memory and an activity flag. Arithmetic works on the element's own registers. Memory operations use one shared address but reach into each element's own memory. A conditional instruction lets every element decide from its own data whether it takes part in the operations that follow.

A host fills the program store through a write port while the block is idle, pulses `start`, and waits for `done`. After the run, a combinational read port shows any element's registers and activity flag. Each instruction spends one cycle in fetch and one cycle in execute.

Top module: `simd_array_ctrl`

## Requirements
- R1: After reset every element register reads 0, every element is active, and `done` is low.
- R2: Each instruction takes exactly two cycles, fetch then execute. `done` goes high 2*N cycles after the edge that captures `start`, where N counts the instructions up to and including the halt. `done` then stays high until the next `start`.
- R3: The instruction word is opcode [15:13], destination register [12:11], source register [10:9], index flag [8] and address/immediate [7:0]. Opcode 0 adds the source register into the destination and opcode 1 subtracts it. Both use each element's own registers and wrap modulo 2^16.
- R4: Opcode 4 writes the 8-bit immediate, zero-extended, to the destination register of every active element. When the index flag is 1, the element's position (0 to 7) is added to the immediate.
- R5: Opcode 2 loads word [7:0] of each element's own memory into its destination register. Opcode 3 stores the destination register into that word of each element's own memory.
- R6: Opcode 5 sets each element's activity flag to 1 when its named register is zero and to 0 otherwise. This is evaluated in every element, idle ones included, so it can reactivate idle elements.
- R7: Opcode 6 makes every element active.
- R8: An idle element changes neither its registers nor its memory for add, subtract, load, store or immediate.
- R9: Opcode 7 halts the sequencer, and no instruction after it is executed. A later `start` runs the program again from address 0, and element state is kept across runs.
- R10: The read port returns the selected element's register and activity flag combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| progWe | input | 1 | Program store write enable |
| progAddr | input | 5 | Program store write address |
| progData | input | 16 | Instruction word to write |
| start | input | 1 | Begin execution at address 0 when idle or done |
| done | output | 1 | High after a halt executes |
| rdPe | input | 3 | Element selected by the read port |
| rdReg | input | 2 | Register selected by the read port |
| rdData | output | 16 | Selected register value |
| rdActive | output | 1 | Selected element's activity flag |

## Verification
The assertions assume that `start` is pulsed only while the sequencer is idle or done, and that the program store is written only outside a run. The bench respects both. It loads each program completely, pulses `start` once, and waits for `done` before it touches any input again. Every program ends with a halt, so the fetch/execute alternation and the rise of `done` always follow from a halt actually executed. The programs sweep arithmetic wrap, per-element immediates, shared-address memory traffic and mask changes, and every element register is compared against an arithmetic model kept in the bench.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int INSTR_W   = 16;
  localparam int REG_IDX_W = 2;
  localparam int REG_NUM   = 1 << REG_IDX_W;
  localparam int ADDR_W    = 8;
  localparam int MEM_DEPTH = 1 << ADDR_W;

  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_SUB    = 3'd1,
    OP_LOAD   = 3'd2,
    OP_STORE  = 3'd3,
    OP_LOADI  = 3'd4,
    OP_SETZ   = 3'd5,
    OP_SETALL = 3'd6,
    OP_HALT   = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    ALU_ADD, ALU_SUB, ALU_LOAD, ALU_IMM
  } aluop_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_FETCH, ST_EXEC, ST_DONE
  } seqstate_e;

  typedef struct packed {
    logic                 exec;
    logic                 regWe;
    logic                 memWe;
    logic                 setCond;
    logic                 setAll;
    logic                 halt;
    aluop_e               aluOp;
    logic [REG_IDX_W-1:0] rd;
    logic [REG_IDX_W-1:0] rs;
    logic                 immIdx;
    logic [ADDR_W-1:0]    field;
  } strobe_t;
endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
#(
  parameter int PROG_DEPTH = 32,
  localparam int PA_W = $clog2(PROG_DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                progWe,
  input  logic [PA_W-1:0]     progAddr,
  input  logic [INSTR_W-1:0]  progData,
  input  logic                start,
  output logic                done,
  output strobe_t             strb
);
  logic [INSTR_W-1:0] progMem [PROG_DEPTH];
  logic [INSTR_W-1:0] ir;
  logic [PA_W-1:0]    pc;
  seqstate_e          state;
  opcode_e            op;

  always_ff @(posedge clk) begin
    if (progWe) progMem[progAddr] <= progData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pc    <= '0;
      ir    <= '0;
      done  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state <= ST_FETCH;
            pc    <= '0;
            done  <= 1'b0;
          end
        end
        ST_FETCH: begin
          ir    <= progMem[pc];
          pc    <= pc + 1'b1;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (op == OP_HALT) begin
            state <= ST_DONE;
            done  <= 1'b1;
          end else begin
            state <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign op = opcode_e'(ir[15:13]);

  always_comb begin
    strb        = '0;
    strb.rd     = ir[12:11];
    strb.rs     = ir[10:9];
    strb.immIdx = ir[8];
    strb.field  = ir[7:0];
    strb.aluOp  = ALU_ADD;
    if (state == ST_EXEC) begin
      strb.exec = 1'b1;
      unique case (op)
        OP_ADD:    begin strb.regWe = 1'b1; strb.aluOp = ALU_ADD;  end
        OP_SUB:    begin strb.regWe = 1'b1; strb.aluOp = ALU_SUB;  end
        OP_LOAD:   begin strb.regWe = 1'b1; strb.aluOp = ALU_LOAD; end
        OP_LOADI:  begin strb.regWe = 1'b1; strb.aluOp = ALU_IMM;  end
        OP_STORE:  strb.memWe   = 1'b1;
        OP_SETZ:   strb.setCond = 1'b1;
        OP_SETALL: strb.setAll  = 1'b1;
        OP_HALT:   strb.halt    = 1'b1;
        default:   strb.halt    = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int unsigned PE_IDX = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [REG_IDX_W-1:0] rdReg,
  output logic [DATA_W-1:0]    rdData,
  output logic                 active
);
  logic [DATA_W-1:0] regs [REG_NUM];
  logic [DATA_W-1:0] mem  [MEM_DEPTH];
  logic [DATA_W-1:0] opA, opB, result, immVal;

  assign opA    = regs[strb.rd];
  assign opB    = regs[strb.rs];
  assign immVal = DATA_W'(strb.field) + (strb.immIdx ? DATA_W'(PE_IDX) : '0);

  always_comb begin
    unique case (strb.aluOp)
      ALU_ADD:  result = opA + opB;
      ALU_SUB:  result = opA - opB;
      ALU_LOAD: result = mem[strb.field];
      default:  result = immVal;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_NUM; i++) regs[i] <= '0;
      active <= 1'b1;
    end else if (strb.exec) begin
      if (strb.setAll)       active <= 1'b1;
      else if (strb.setCond) active <= (opA == '0);
      else if (strb.regWe && active) regs[strb.rd] <= result;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.exec && strb.memWe && active) mem[strb.field] <= opA;
  end

  assign rdData = regs[rdReg];
endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array
  import simd_pkg::*;
#(
  parameter int NUM_PE = 8,
  parameter int DATA_W = 16,
  localparam int PE_W = $clog2(NUM_PE)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [PE_W-1:0]      rdPe,
  input  logic [REG_IDX_W-1:0] rdReg,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdActive,
  output logic [NUM_PE-1:0]    actVec
);
  logic [DATA_W-1:0] peRd [NUM_PE];

  for (genvar g = 0; g < NUM_PE; g++) begin : genPe
    simd_pe #(.DATA_W(DATA_W), .PE_IDX(g)) uPe (
      .clk    (clk),
      .rstN   (rstN),
      .strb   (strb),
      .rdReg  (rdReg),
      .rdData (peRd[g]),
      .active (actVec[g])
    );
  end

  assign rdData   = peRd[rdPe];
  assign rdActive = actVec[rdPe];
endmodule

// File: rtl/simd_array_ctrl.sv
module simd_array_ctrl
  import simd_pkg::*;
#(
  parameter int NUM_PE     = 8,
  parameter int DATA_W     = 16,
  parameter int PROG_DEPTH = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          progWe,
  input  logic [$clog2(PROG_DEPTH)-1:0] progAddr,
  input  logic [15:0]                   progData,
  input  logic                          start,
  output logic                          done,
  input  logic [$clog2(NUM_PE)-1:0]     rdPe,
  input  logic [1:0]                    rdReg,
  output logic [DATA_W-1:0]             rdData,
  output logic                          rdActive
);
  strobe_t           strb;
  logic [NUM_PE-1:0] actVec;

  simd_ctrl #(.PROG_DEPTH(PROG_DEPTH)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .progWe   (progWe),
    .progAddr (progAddr),
    .progData (progData),
    .start    (start),
    .done     (done),
    .strb     (strb)
  );

  simd_pe_array #(.NUM_PE(NUM_PE), .DATA_W(DATA_W)) uArray (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdPe     (rdPe),
    .rdReg    (rdReg),
    .rdData   (rdData),
    .rdActive (rdActive),
    .actVec   (actVec)
  );
endmodule

// File: rtl/simd_array_chk.sv
module simd_array_chk
  import simd_pkg::*;
#(
  parameter int NUM_PE = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              done,
  input strobe_t           strb,
  input logic [NUM_PE-1:0] actVec
);
  assert_done_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done);

  assert_exec_alternates_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.exec |=> !strb.exec);

  assert_setall_wakes_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.exec && strb.setAll |=> &actVec);

  assert_done_from_halt_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(strb.exec && strb.halt));

  assert_quiet_when_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !strb.exec);
endmodule

bind simd_array_ctrl simd_array_chk #(.NUM_PE(NUM_PE)) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .done   (done),
  .strb   (strb),
  .actVec (actVec)
);

// File: tb/tb_simd_array_ctrl.sv
`timescale 1ns/1ps
module tb_simd_array_ctrl;
  localparam int NPE = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        progWe = 1'b0;
  logic [4:0]  progAddr = '0;
  logic [15:0] progData = '0;
  logic        start = 1'b0;
  logic        done;
  logic [2:0]  rdPe = '0;
  logic [1:0]  rdReg = '0;
  logic [15:0] rdData;
  logic        rdActive;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [15:0] prog [32];
  logic [15:0] mReg [NPE][4];
  logic [15:0] mMem [NPE][256];
  logic        mAct [NPE];

  always #10 clk = ~clk;

  simd_array_ctrl dut (
    .clk(clk), .rstN(rstN), .progWe(progWe), .progAddr(progAddr),
    .progData(progData), .start(start), .done(done), .rdPe(rdPe),
    .rdReg(rdReg), .rdData(rdData), .rdActive(rdActive)
  );

  function automatic logic [15:0] enc(int op, int rd, int rs, int idx, int f);
    return {3'(op), 2'(rd), 2'(rs), 1'(idx), 8'(f)};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Sequential model of the instruction set, from the requirements.
  task automatic modelRun(output int n);
    n = 0;
    for (int pc = 0; pc < 32; pc++) begin
      logic [2:0] op; logic [1:0] rd, rs; logic ix; logic [7:0] f;
      {op, rd, rs, ix, f} = prog[pc];
      n++;
      if (op == 3'd7) break;
      for (int p = 0; p < NPE; p++) begin
        case (op)
          3'd0: if (mAct[p]) mReg[p][rd] = mReg[p][rd] + mReg[p][rs];
          3'd1: if (mAct[p]) mReg[p][rd] = mReg[p][rd] - mReg[p][rs];
          3'd2: if (mAct[p]) mReg[p][rd] = mMem[p][f];
          3'd3: if (mAct[p]) mMem[p][f] = mReg[p][rd];
          3'd4: if (mAct[p]) mReg[p][rd] = 16'(f) + (ix ? 16'(p) : 16'd0);
          3'd5: mAct[p] = (mReg[p][rd] == 16'd0);
          default: mAct[p] = 1'b1;
        endcase
      end
    end
  endtask

  task automatic compareAll(string tag);
    for (int p = 0; p < NPE; p++) begin
      for (int r = 0; r < 4; r++) begin
        @(negedge clk); rdPe = 3'(p); rdReg = 2'(r); #1;
        check(tag, rdData, mReg[p][r], $sformatf("R10 pe%0d reg%0d", p, r));
      end
      check(tag, 16'(rdActive), 16'(mAct[p]), $sformatf("active pe%0d", p));
    end
  endtask

  task automatic runProgram(string tag, int len);
    int n, cnt;
    for (int i = 0; i < len; i++) begin
      @(negedge clk); progWe = 1'b1; progAddr = 5'(i); progData = prog[i];
    end
    @(negedge clk); progWe = 1'b0;
    modelRun(n);
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    cnt = 0;
    while (!done && cnt < 1000) begin
      @(posedge clk); #1; cnt++;
    end
    check("R2", 16'(cnt), 16'(2 * n), {tag, " cycles to done"});
    repeat (3) @(posedge clk);
    #1 check("R2", 16'(done), 16'd1, {tag, " done held"});
    compareAll(tag);
  endtask

  initial begin
    for (int p = 0; p < NPE; p++) begin
      for (int r = 0; r < 4; r++) mReg[p][r] = '0;
      mAct[p] = 1'b1;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1 check("R1", 16'(done), 16'd0, "done after reset");
    compareAll("R1");

    // R3 R4: arithmetic with wrap and per-element immediates
    prog[0] = enc(4, 0, 0, 1, 10);
    prog[1] = enc(4, 1, 0, 0, 7);
    prog[2] = enc(0, 0, 1, 0, 0);
    prog[3] = enc(1, 1, 0, 0, 0);
    prog[4] = enc(4, 2, 0, 0, 255);
    prog[5] = enc(0, 2, 2, 0, 0);
    prog[6] = enc(4, 3, 0, 1, 0);
    prog[7] = enc(1, 3, 1, 0, 0);
    prog[8] = enc(7, 0, 0, 0, 0);
    runProgram("R3 R4", 9);

    // R5: shared address, private memories, including words 0 and 255
    prog[0] = enc(4, 0, 0, 1, 1);
    prog[1] = enc(3, 0, 0, 0, 200);
    prog[2] = enc(4, 0, 0, 0, 0);
    prog[3] = enc(2, 3, 0, 0, 200);
    prog[4] = enc(3, 3, 0, 0, 255);
    prog[5] = enc(4, 1, 0, 1, 100);
    prog[6] = enc(3, 1, 0, 0, 0);
    prog[7] = enc(2, 2, 0, 0, 255);
    prog[8] = enc(2, 0, 0, 0, 0);
    prog[9] = enc(7, 0, 0, 0, 0);
    runProgram("R5 R9", 10);

    // R6 R8: mask to element 3, then a condition that wakes idle element 0
    prog[0]  = enc(4, 1, 0, 0, 42);
    prog[1]  = enc(3, 1, 0, 0, 10);
    prog[2]  = enc(4, 0, 0, 1, 0);
    prog[3]  = enc(4, 2, 0, 0, 3);
    prog[4]  = enc(1, 0, 2, 0, 0);
    prog[5]  = enc(4, 3, 0, 1, 0);
    prog[6]  = enc(5, 0, 0, 0, 0);
    prog[7]  = enc(4, 1, 0, 0, 99);
    prog[8]  = enc(3, 1, 0, 0, 10);
    prog[9]  = enc(0, 3, 1, 0, 0);
    prog[10] = enc(5, 3, 0, 0, 0);
    prog[11] = enc(4, 2, 0, 0, 77);
    prog[12] = enc(2, 1, 0, 0, 10);
    prog[13] = enc(7, 0, 0, 0, 0);
    runProgram("R6 R8", 14);

    // R7 R9: wake all, read masked memory, nothing after halt runs
    prog[0] = enc(6, 0, 0, 0, 0);
    prog[1] = enc(2, 0, 0, 0, 10);
    prog[2] = enc(7, 0, 0, 0, 0);
    prog[3] = enc(4, 1, 0, 0, 1);
    prog[4] = enc(4, 2, 0, 0, 2);
    runProgram("R7 R9", 5);

    // R6 sweep: condition on each register in turn
    for (int r = 0; r < 4; r++) begin
      prog[0] = enc(6, 0, 0, 0, 0);
      prog[1] = enc(4, r, 0, 1, 0);
      prog[2] = enc(5, r, 0, 0, 0);
      prog[3] = enc(4, (r + 1) % 4, 0, 0, 5 + r);
      prog[4] = enc(7, 0, 0, 0, 0);
      runProgram("R6 sweep", 5);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired R2 actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule